// File: doc/BRIEF.md
# Receive Nibble Stream Framer and Length Qualifier

This block sits on the receive side of a 10/100 media access controller, behind the stage that has already brought the 4-bit media-independent-interface nibbles and their data-valid flag into the chip clock domain. It delays the nibble stream through a short register pipeline. Beside the delayed stream it marks where each frame begins and ends, with one-cycle pulses that line up with the delayed nibbles, so that the stages downstream see data and frame markers in the same cycle.

While a frame goes by, the block counts its nibbles. The count saturates instead of wrapping. When the last nibble has passed, the block shows the final nibble count and whether the frame's byte length falls inside the legal window of 64 to 1518 bytes. Both values stay unchanged until the next frame starts. Frames must be separated by at least one cycle with valid low. The pipeline depth and the byte limits are parameters. The defaults are one stage and 64/1518 bytes.

Top module: `rx_frame_delim`

## Requirements
- R1: `rxd_o` and `rxdv_o` equal `rxd_i` and `rxdv_i` delayed by exactly `DLY_STAGES` clock cycles (default 1), whether valid is high or low.
- R2: `sof_o` is high for exactly one cycle, in the cycle where `rxdv_o` first goes high after being low, which is the first nibble of a frame on the delayed stream.
- R3: `eof_o` is high for exactly one cycle, in the cycle where `rxdv_o` is high and the following delayed nibble has valid low, which is the last nibble of a frame.
- R4: For a frame of one nibble, `sof_o` and `eof_o` are both high in the same cycle.
- R5: From the cycle after `eof_o`, `len_o` holds the frame's length in nibbles as a 12-bit count.
- R6: The nibble count saturates at 4095. For a frame longer than 4095 nibbles, `len_o` reads 4095 and does not wrap.
- R7: From the cycle after `eof_o`, `len_ok_o` is 1 when the frame's nibble count is between 128 and 3036 inclusive (64 to 1518 bytes), and 0 otherwise. The boundary lengths 127, 128, 3036 and 3037 give 0, 1, 1 and 0.
- R8: `len_o` and `len_ok_o` stay stable from the cycle after `eof_o` up to and including the next `sof_o` cycle.
- R9: While `rst_ni` is low, every output is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Chip clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| rxd_i | input | 4 | Receive nibble, chip clock domain |
| rxdv_i | input | 1 | Receive data valid |
| rxd_o | output | 4 | Delayed receive nibble |
| rxdv_o | output | 1 | Delayed data valid |
| sof_o | output | 1 | Start-of-frame pulse, aligned to the first delayed nibble |
| eof_o | output | 1 | End-of-frame pulse, aligned to the last delayed nibble |
| len_o | output | 12 | Nibble count of the frame, saturating |
| len_ok_o | output | 1 | Frame byte length lies within the legal window |

## Verification
The frames vary in length, gap and data pattern. Frames of one and two nibbles separate the single-cycle case, where start and end coincide, from the case where they are adjacent. Gaps of one idle cycle and of several idle cycles show whether the start detector needs more than one low cycle to re-arm. Lengths of 127, 128, 3036 and 3037 nibbles probe both edges of the legality window, and a 4100-nibble frame separates saturation from wrap-around. Counting and alternating nibble patterns check that the delayed data is not reordered or corrupted.

// File: rtl/rx_frame_pkg.sv
package rx_frame_pkg;
  localparam int unsigned NIB_W = 4;

  typedef struct packed {
    logic             sof;
    logic             vld;
    logic [NIB_W-1:0] nib;
  } rx_beat_t;
endpackage

// File: rtl/rx_delay_line.sv
module rx_delay_line
  import rx_frame_pkg::*;
#(
  parameter int unsigned STAGES = 1
) (
  input  logic     clk_i,
  input  logic     rst_ni,
  input  rx_beat_t beat_i,
  output rx_beat_t beat_o,
  output logic     first_vld_o,
  output logic     prev_vld_o
);
  rx_beat_t tap [STAGES+1];

  assign tap[0] = beat_i;

  for (genvar g = 1; g <= STAGES; g++) begin : gen_stg
    rx_beat_t q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) q <= '0;
      else         q <= tap[g-1];
    end
    assign tap[g] = q;
  end

  assign beat_o      = tap[STAGES];
  assign first_vld_o = tap[1].vld;
  // the stage just upstream of the output; the raw input when STAGES == 1
  assign prev_vld_o  = tap[STAGES-1].vld;
endmodule

// File: rtl/rx_edge_mark.sv
module rx_edge_mark (
  input  logic rxdv_i,
  input  logic first_vld_i,
  input  logic out_vld_i,
  input  logic prev_vld_i,
  output logic sof_in_o,
  output logic eof_o
);
  // start marked on entry into the pipe, carried alongside the nibble
  assign sof_in_o = rxdv_i & ~first_vld_i;
  // end needs one nibble of look-ahead: the stage behind the output
  assign eof_o    = out_vld_i & ~prev_vld_i;
endmodule

// File: rtl/rx_len_check.sv
module rx_len_check #(
  parameter int unsigned LEN_W     = 12,
  parameter int unsigned MIN_BYTES = 64,
  parameter int unsigned MAX_BYTES = 1518
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             vld_i,
  input  logic             sof_i,
  input  logic             eof_i,
  output logic [LEN_W-1:0] len_o,
  output logic             len_ok_o
);
  localparam logic [LEN_W-1:0] CNT_MAX = {LEN_W{1'b1}};
  localparam logic [LEN_W-1:0] MIN_NIB = LEN_W'(2 * MIN_BYTES);
  localparam logic [LEN_W-1:0] MAX_NIB = LEN_W'(2 * MAX_BYTES);

  logic [LEN_W-1:0] cnt_q, cnt_nx;
  logic             ok_q, ok_nx;

  always_comb begin
    if (sof_i)                cnt_nx = LEN_W'(1);
    else if (cnt_q == CNT_MAX) cnt_nx = cnt_q;
    else                      cnt_nx = cnt_q + LEN_W'(1);
    ok_nx = (cnt_nx >= MIN_NIB) && (cnt_nx <= MAX_NIB);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      ok_q  <= 1'b0;
    end else if (vld_i) begin
      cnt_q <= cnt_nx;
      if (eof_i)      ok_q <= ok_nx;
      else if (sof_i) ok_q <= 1'b0;
    end
  end

  assign len_o    = cnt_q;
  assign len_ok_o = ok_q;

  p_sat_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q == CNT_MAX && vld_i && !sof_i) |=> (cnt_q == CNT_MAX));

  p_ok_range_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ok_q |-> (cnt_q >= MIN_NIB && cnt_q <= MAX_NIB));

  p_hold_len_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !vld_i |=> ($stable(cnt_q) && $stable(ok_q)));
endmodule

// File: rtl/rx_frame_delim.sv
module rx_frame_delim
  import rx_frame_pkg::*;
#(
  parameter int unsigned DLY_STAGES = 1,
  parameter int unsigned LEN_W      = 12,
  parameter int unsigned MIN_BYTES  = 64,
  parameter int unsigned MAX_BYTES  = 1518
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [3:0]       rxd_i,
  input  logic             rxdv_i,
  output logic [3:0]       rxd_o,
  output logic             rxdv_o,
  output logic             sof_o,
  output logic             eof_o,
  output logic [LEN_W-1:0] len_o,
  output logic             len_ok_o
);
  rx_beat_t beat_in, beat_out;
  logic     first_vld, prev_vld, sof_in;

  assign beat_in = '{sof: sof_in, vld: rxdv_i, nib: rxd_i};

  rx_delay_line #(.STAGES(DLY_STAGES)) u_dly (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .beat_i      (beat_in),
    .beat_o      (beat_out),
    .first_vld_o (first_vld),
    .prev_vld_o  (prev_vld)
  );

  rx_edge_mark u_mark (
    .rxdv_i      (rxdv_i),
    .first_vld_i (first_vld),
    .out_vld_i   (beat_out.vld),
    .prev_vld_i  (prev_vld),
    .sof_in_o    (sof_in),
    .eof_o       (eof_o)
  );

  rx_len_check #(
    .LEN_W     (LEN_W),
    .MIN_BYTES (MIN_BYTES),
    .MAX_BYTES (MAX_BYTES)
  ) u_len (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .vld_i    (beat_out.vld),
    .sof_i    (sof_o),
    .eof_i    (eof_o),
    .len_o    (len_o),
    .len_ok_o (len_ok_o)
  );

  assign rxd_o  = beat_out.nib;
  assign rxdv_o = beat_out.vld;
  assign sof_o  = beat_out.sof;

  p_sof_with_vld_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sof_o |-> rxdv_o);

  p_sof_after_idle_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sof_o |-> !$past(rxdv_o));

  p_vld_rise_sof_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rxdv_o) |-> sof_o);

  p_eof_then_idle_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eof_o |=> !rxdv_o);

  p_vld_fall_eof_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rxdv_o && !eof_o) |=> rxdv_o);

  p_len_after_eof_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (eof_o && sof_o) |=> (len_o == LEN_W'(1)));
endmodule

// File: tb/rx_frame_delim_tb_top.sv
module rx_frame_delim_tb_top;
  localparam int unsigned DLY   = 1;
  localparam int unsigned LEN_W = 12;
  localparam int          CMAX  = 4095;

  typedef struct packed { logic v; logic [3:0] d; } item_t;
  typedef struct packed { logic [LEN_W-1:0] len; logic ok; } fexp_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [3:0] rxd_i = '0;
  logic rxdv_i = 1'b0;
  logic [3:0] rxd_o;
  logic rxdv_o, sof_o, eof_o, len_ok_o;
  logic [LEN_W-1:0] len_o;

  int n_tests = 0;
  int n_fail  = 0;
  bit mon_en  = 0;
  bit done    = 0;
  item_t exp_q[$];
  fexp_t len_q[$];

  always #10 clk = ~clk;

  rx_frame_delim dut_i (
    .clk_i(clk), .rst_ni(rst_n), .rxd_i(rxd_i), .rxdv_i(rxdv_i),
    .rxd_o(rxd_o), .rxdv_o(rxdv_o), .sof_o(sof_o), .eof_o(eof_o),
    .len_o(len_o), .len_ok_o(len_ok_o)
  );

  task automatic chk(string req, int act, int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic drive(logic v, logic [3:0] d);
    @(negedge clk);
    rxdv_i = v;
    rxd_i  = d;
    exp_q.push_back('{v: v, d: d});
    mon_en = 1;
  endtask

  task automatic send_frame(int n, int gap, int pat);
    fexp_t f;
    f.len = (n > CMAX) ? LEN_W'(CMAX) : LEN_W'(n);
    f.ok  = (n >= 128) && (n <= 3036);
    len_q.push_back(f);
    for (int i = 0; i < n; i++)
      drive(1'b1, (pat == 0) ? 4'(i) : ((i % 2) ? 4'hA : 4'h5));
    for (int i = 0; i < gap; i++) drive(1'b0, 4'h0);
  endtask

  // monitor: scoreboard against the queued stream
  initial begin
    item_t cur;
    logic prev_v = 1'b0;
    bit pend = 0, held = 0;
    int hold_len = 0, hold_ok = 0;
    fexp_t f;
    forever begin
      @(negedge clk);
      #2;
      if (mon_en && exp_q.size() > DLY) begin
        cur = exp_q.pop_front();
        chk("R1 data", int'(rxd_o), int'(cur.d));
        chk("R1 valid", int'(rxdv_o), int'(cur.v));
        chk("R2 sof", int'(sof_o), int'(cur.v & ~prev_v));
        chk("R3 eof", int'(eof_o), int'(cur.v & ~exp_q[0].v));
        if (cur.v && !prev_v && !exp_q[0].v)
          chk("R4 sof+eof single", int'(sof_o & eof_o), 1);
        if (pend) begin
          f = len_q.pop_front();
          chk(f.len == LEN_W'(CMAX) ? "R6 saturated len" : "R5 len", int'(len_o), int'(f.len));
          chk("R7 len_ok", int'(len_ok_o), int'(f.ok));
          hold_len = int'(len_o);
          hold_ok  = int'(len_ok_o);
          pend = 0;
          held = 1;
        end else if (held) begin
          chk("R8 len held", int'(len_o), hold_len);
          chk("R8 ok held", int'(len_ok_o), hold_ok);
        end
        if (cur.v && !prev_v) held = 0;
        if (cur.v && !exp_q[0].v) pend = 1;
        prev_v = cur.v;
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    #2;
    chk("R9 rxd reset", int'(rxd_o), 0);
    chk("R9 rxdv reset", int'(rxdv_o), 0);
    chk("R9 sof reset", int'(sof_o), 0);
    chk("R9 eof reset", int'(eof_o), 0);
    chk("R9 len reset", int'(len_o), 0);
    chk("R9 ok reset", int'(len_ok_o), 0);
    for (int i = 0; i < DLY; i++) exp_q.push_back('0);
    @(negedge clk);
    rst_n = 1'b1;
    for (int i = 0; i < 3; i++) drive(1'b0, 4'h0);
    send_frame(1, 1, 0);     // R4
    send_frame(2, 1, 1);
    send_frame(1, 3, 1);     // R4 after short gap
    send_frame(5, 1, 0);
    send_frame(127, 2, 0);   // R7 below window
    send_frame(128, 1, 1);   // R7 lower edge
    send_frame(300, 4, 0);
    send_frame(3036, 1, 0);  // R7 upper edge
    send_frame(3037, 2, 1);  // R7 above window
    send_frame(4100, 3, 0);  // R6 saturation
    send_frame(200, 5, 1);
    send_frame(1, 4, 0);
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    @(negedge clk);
    #5;
    if (len_q.size() != 0) begin
      n_tests++;
      n_fail++;
      $display("FAIL R5 frames unchecked: actual %0d expected 0", len_q.size());
    end
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule